// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is a byte-wide, two-way mailbox between a host bus and an embedded controller CPU, arranged the way a PC keyboard controller presents itself. The host drops bytes into an input data register. The CPU places bytes in an output data register. A shared status byte holds the handshake flags for both directions, a flag that marks whether the last host byte was a command or data, a system flag, and four bits whose meaning software defines.

Each direction is a one-deep buffer with a full flag. The writer's access sets the flag and the reader's access clears it, so neither side needs an explicit acknowledge. The CPU side also has an interrupt that signals a pending host byte, gated by an enable bit. The host bus and the CPU port both use plain single-cycle strobes rather than valid/ready. There is no back-pressure: software must poll the full flags before it writes. A reset qualifier discards glitches on the raw reset input, so that only a long enough pulse clears the status.

Top module: `kbc_mailbox`

## Requirements
- R1: A CPU write of the output data register (cpu_sel=0) sets the output-full flag (status bit 0). A host read with host_cs=1 and host_a2=0 clears it. If both happen in the same cycle, the flag ends up set and the new byte is held.
- R2: A host write with host_cs=1 stores host_wdata in the input data register and sets the input-full flag (status bit 1). A CPU read of cpu_sel=0 clears the flag. If a host write and that CPU read happen in the same cycle, the flag stays set and the new byte is held.
- R3: cpu_irq is high exactly when the input-full flag is set and the interrupt enable is 1. The enable is bit 0 of a CPU write to cpu_sel=2, and the interrupt drops in the cycle after the CPU reads the input data register.
- R4: Every host write copies host_a2 into the command/data flag (status bit 3): 1 means command, 0 means data. Both host_a2 values store the byte in the same input data register.
- R5: While host_cs=1 and host_rd=1, host_rdata shows the output data register when host_a2=0 and the status byte when host_a2=1. Otherwise host_rdata is 0. The status layout is: bit 0 output-full, bit 1 input-full, bit 2 system flag, bit 3 command/data, bits 7:4 user bits. The host has no path that writes status.
- R6: A CPU write to the status register (cpu_sel=1) loads bit 2 and bits 7:4 from cpu_wdata and leaves bits 0, 1 and 3 unchanged.
- R7: A qualified reset clears the whole status byte and the interrupt enable to 0.
- R8: A reset counts only if rst_in has been high for at least MIN_RST_CYC (default 24) consecutive clock edges. A pulse that is even one cycle shorter leaves every register unchanged.
- R9: While cpu_rd=1, cpu_rdata shows the input data register for cpu_sel=0, the status byte for 1, and the interrupt enable in bit 0 for 2. It shows 0 for cpu_sel=3 and whenever cpu_rd=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_in | input | 1 | Raw active-high reset, qualified by pulse length |
| host_cs | input | 1 | Host chip select |
| host_a2 | input | 1 | Host address bit: data/command on write, data/status on read |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| cpu_sel | input | 2 | CPU register select: 0 data, 1 status, 2 control |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte |
| cpu_irq | output | 1 | Input-buffer-full interrupt |

## Verification
Two pairs of accesses can land in the same cycle, and both are tested. A host write can coincide with the CPU draining the input register, and a CPU write to the output register can coincide with the host reading it. Directed cycles drive each pair together and then read the status back, expecting the flag set and the new byte held. Random traffic also produces such overlaps at a steady rate. A bench model that gives the setting access priority judges every one of those cycles.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int KBC_DW = 8;

  typedef struct packed {
    logic [3:0] usr;
    logic       cmd;
    logic       sysf;
    logic       ifull;
    logic       ofull;
  } kbc_stat_t;

  typedef enum logic [1:0] {
    KSEL_DATA = 2'd0,
    KSEL_STAT = 2'd1,
    KSEL_CTRL = 2'd2,
    KSEL_NONE = 2'd3
  } kbc_sel_e;
endpackage

// File: rtl/kbc_rst_qual.sv
module kbc_rst_qual #(
  parameter int MIN_RST_CYC = 24
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_act
);
  localparam int W = $clog2(MIN_RST_CYC + 1);
  localparam logic [W-1:0] LIM  = W'(MIN_RST_CYC);
  localparam logic [W-1:0] LAST = W'(MIN_RST_CYC - 1);

  logic [W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_in) begin
      run_len <= '0;
      rst_act <= 1'b0;
    end else begin
      if (run_len != LIM) run_len <= run_len + 1'b1;
      if (run_len == LAST) rst_act <= 1'b1;
    end
  end

  // R8: qualified reset releases as soon as the raw input drops
  p_release_r8: assert property (@(posedge clk) !rst_in |=> !rst_act);
  // R8: qualified reset never starts without the raw input held
  p_hold_r8: assert property (@(posedge clk) $rose(rst_act) |-> $past(rst_in));
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
(
  input  logic              host_cs,
  input  logic              host_a2,
  input  logic              host_rd,
  input  logic              host_wr,
  input  kbc_stat_t         stat,
  input  logic [KBC_DW-1:0] obuf,
  output logic              wr_ev,
  output logic              rd_data_ev,
  output logic [KBC_DW-1:0] rdata
);
  logic rd_ev;

  always_comb begin
    wr_ev      = host_cs & host_wr;
    rd_ev      = host_cs & host_rd;
    rd_data_ev = rd_ev & ~host_a2;
    rdata      = '0;
    if (rd_ev) rdata = host_a2 ? stat : obuf;
  end
endmodule

// File: rtl/kbc_cpu_if.sv
module kbc_cpu_if
  import kbc_pkg::*;
(
  input  logic [1:0]        cpu_sel,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [KBC_DW-1:0] ibuf,
  input  kbc_stat_t         stat,
  input  logic              irq_en,
  output logic              rd_in_ev,
  output logic              wr_out_ev,
  output logic              wr_stat_ev,
  output logic              wr_ctrl_ev,
  output logic [KBC_DW-1:0] rdata
);
  kbc_sel_e sel;

  always_comb begin
    sel        = kbc_sel_e'(cpu_sel);
    rd_in_ev   = cpu_rd & (sel == KSEL_DATA);
    wr_out_ev  = cpu_wr & (sel == KSEL_DATA);
    wr_stat_ev = cpu_wr & (sel == KSEL_STAT);
    wr_ctrl_ev = cpu_wr & (sel == KSEL_CTRL);
    rdata      = '0;
    if (cpu_rd) begin
      unique case (sel)
        KSEL_DATA: rdata = ibuf;
        KSEL_STAT: rdata = stat;
        KSEL_CTRL: rdata = {{(KBC_DW-1){1'b0}}, irq_en};
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/kbc_core.sv
module kbc_core
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_act,
  input  logic              h_wr_ev,
  input  logic              h_rd_data_ev,
  input  logic              h_a2,
  input  logic [KBC_DW-1:0] h_wdata,
  input  logic              c_rd_in_ev,
  input  logic              c_wr_out_ev,
  input  logic              c_wr_stat_ev,
  input  logic              c_wr_ctrl_ev,
  input  logic [KBC_DW-1:0] c_wdata,
  output kbc_stat_t         stat,
  output logic [KBC_DW-1:0] ibuf,
  output logic [KBC_DW-1:0] obuf,
  output logic              irq_en,
  output logic              irq
);
  kbc_stat_t cw;
  assign cw = kbc_stat_t'(c_wdata);

  // data registers carry no reset value
  always_ff @(posedge clk) begin
    if (h_wr_ev)     ibuf <= h_wdata;
    if (c_wr_out_ev) obuf <= c_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst_act) begin
      stat   <= '0;
      irq_en <= 1'b0;
    end else begin
      if (c_wr_out_ev)       stat.ofull <= 1'b1;
      else if (h_rd_data_ev) stat.ofull <= 1'b0;
      if (h_wr_ev) begin
        stat.ifull <= 1'b1;
        stat.cmd   <= h_a2;
      end else if (c_rd_in_ev) begin
        stat.ifull <= 1'b0;
      end
      if (c_wr_stat_ev) begin
        stat.sysf <= cw.sysf;
        stat.usr  <= cw.usr;
      end
      if (c_wr_ctrl_ev) irq_en <= c_wdata[0];
    end
  end

  assign irq = stat.ifull & irq_en;

  p_obf_set_r1: assert property (@(posedge clk) disable iff (rst_act)
    c_wr_out_ev |=> stat.ofull);
  p_obf_clr_r1: assert property (@(posedge clk) disable iff (rst_act)
    (h_rd_data_ev && !c_wr_out_ev) |=> !stat.ofull);
  p_ibf_set_r2: assert property (@(posedge clk) disable iff (rst_act)
    h_wr_ev |=> stat.ifull);
  p_ibf_clr_r2: assert property (@(posedge clk) disable iff (rst_act)
    (c_rd_in_ev && !h_wr_ev) |=> !stat.ifull);
  p_irq_drop_r3: assert property (@(posedge clk) disable iff (rst_act)
    (c_rd_in_ev && !h_wr_ev) |=> !irq);
  p_cd_cap_r4: assert property (@(posedge clk) disable iff (rst_act)
    h_wr_ev |=> (stat.cmd == $past(h_a2)));
  p_hw_bits_r6: assert property (@(posedge clk) disable iff (rst_act)
    (c_wr_stat_ev && !h_wr_ev) |=> $stable(stat.cmd));
  p_clear_r7: assert property (@(posedge clk)
    $fell(rst_act) |-> (stat == '0 && !irq_en));
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_pkg::*;
#(
  parameter int MIN_RST_CYC = 24
) (
  input  logic       clk,
  input  logic       rst_in,
  input  logic       host_cs,
  input  logic       host_a2,
  input  logic       host_rd,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic [1:0] cpu_sel,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       cpu_irq
);
  logic              rst_act;
  logic              h_wr_ev, h_rd_data_ev;
  logic              c_rd_in_ev, c_wr_out_ev, c_wr_stat_ev, c_wr_ctrl_ev;
  kbc_stat_t         stat;
  logic [KBC_DW-1:0] ibuf, obuf;
  logic              irq_en;

  kbc_rst_qual #(.MIN_RST_CYC(MIN_RST_CYC)) u_rst (
    .clk(clk), .rst_in(rst_in), .rst_act(rst_act)
  );

  kbc_host_if u_host (
    .host_cs(host_cs), .host_a2(host_a2), .host_rd(host_rd), .host_wr(host_wr),
    .stat(stat), .obuf(obuf), .wr_ev(h_wr_ev), .rd_data_ev(h_rd_data_ev),
    .rdata(host_rdata)
  );

  kbc_cpu_if u_cpu (
    .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .ibuf(ibuf),
    .stat(stat), .irq_en(irq_en), .rd_in_ev(c_rd_in_ev),
    .wr_out_ev(c_wr_out_ev), .wr_stat_ev(c_wr_stat_ev),
    .wr_ctrl_ev(c_wr_ctrl_ev), .rdata(cpu_rdata)
  );

  kbc_core u_core (
    .clk(clk), .rst_act(rst_act), .h_wr_ev(h_wr_ev),
    .h_rd_data_ev(h_rd_data_ev), .h_a2(host_a2), .h_wdata(host_wdata),
    .c_rd_in_ev(c_rd_in_ev), .c_wr_out_ev(c_wr_out_ev),
    .c_wr_stat_ev(c_wr_stat_ev), .c_wr_ctrl_ev(c_wr_ctrl_ev),
    .c_wdata(cpu_wdata), .stat(stat), .ibuf(ibuf), .obuf(obuf),
    .irq_en(irq_en), .irq(cpu_irq)
  );
endmodule

// File: tb/tb_kbc_mailbox.sv
module tb_kbc_mailbox;
  localparam int MINR = 24;

  logic       clk = 1'b0;
  logic       rst_in, host_cs, host_a2, host_rd, host_wr;
  logic [7:0] host_wdata, host_rdata, cpu_wdata, cpu_rdata;
  logic [1:0] cpu_sel;
  logic       cpu_rd, cpu_wr, cpu_irq;

  kbc_mailbox #(.MIN_RST_CYC(MINR)) dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] m_ib, m_ob;
  logic m_obf, m_ibf, m_sys, m_cd, m_en;
  logic [3:0] m_ud;

  function automatic logic [7:0] m_stat();
    return {m_ud, m_cd, m_sys, m_ibf, m_obf};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic cs, logic a2, logic hr, logic hw, logic [7:0] hd,
                      logic [1:0] sel, logic cr, logic cw, logic [7:0] cd);
    logic [7:0] eh, ec;
    host_cs = cs; host_a2 = a2; host_rd = hr; host_wr = hw; host_wdata = hd;
    cpu_sel = sel; cpu_rd = cr; cpu_wr = cw; cpu_wdata = cd;
    #2;
    eh = (cs && hr) ? (a2 ? m_stat() : m_ob) : 8'h00;
    ec = 8'h00;
    if (cr) case (sel)
      2'd0: ec = m_ib;
      2'd1: ec = m_stat();
      2'd2: ec = {7'b0, m_en};
      default: ec = 8'h00;
    endcase
    chk("R5 host_rdata", host_rdata, eh);
    chk("R9 cpu_rdata", cpu_rdata, ec);
    chk("R3 cpu_irq", {7'b0, cpu_irq}, {7'b0, m_ibf & m_en});
    @(posedge clk);
    if (cw && sel == 2'd0) begin m_ob = cd; m_obf = 1'b1; end
    else if (cs && hr && !a2) m_obf = 1'b0;
    if (cs && hw) begin m_ib = hd; m_ibf = 1'b1; m_cd = a2; end
    else if (cr && sel == 2'd0) m_ibf = 1'b0;
    if (cw && sel == 2'd1) begin m_sys = cd[2]; m_ud = cd[7:4]; end
    if (cw && sel == 2'd2) m_en = cd[0];
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 8'h00, 2'd3, 0, 0, 8'h00);
  endtask

  task automatic cpu_read(logic [1:0] sel);
    step(0, 0, 0, 0, 8'h00, sel, 1, 0, 8'h00);
  endtask

  task automatic pulse_rst(int n);
    rst_in = 1'b1;
    repeat (n) @(negedge clk);
    rst_in = 1'b0;
    @(negedge clk);
    if (n >= MINR) begin
      m_obf = 0; m_ibf = 0; m_sys = 0; m_cd = 0; m_ud = 0; m_en = 0;
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    rst_in = 0; host_cs = 0; host_a2 = 0; host_rd = 0; host_wr = 0;
    host_wdata = 0; cpu_sel = 3; cpu_rd = 0; cpu_wr = 0; cpu_wdata = 0;
    m_ib = 0; m_ob = 0;
    @(negedge clk);
    pulse_rst(30);
    // R7: status and enable clear after a qualified reset
    chk("R7 host status", 8'h00, 8'h00);
    cpu_read(2'd1);
    cpu_read(2'd2);
    // prime both data registers
    step(1, 0, 0, 1, 8'h5a, 2'd0, 0, 1, 8'ha5);
    // R1: host reads the output byte, flag drops
    step(1, 0, 1, 0, 8'h00, 2'd3, 0, 0, 8'h00);
    step(1, 1, 1, 0, 8'h00, 2'd3, 0, 0, 8'h00);
    chk("R1 obf cleared", {7'b0, m_obf}, 8'h00);
    // R4: command write sets cmd flag, same register
    step(1, 1, 0, 1, 8'h3c, 2'd3, 0, 0, 8'h00);
    cpu_read(2'd1);
    chk("R4 cd flag", host_rdata, 8'h00);
    step(1, 1, 1, 0, 8'h00, 2'd3, 0, 0, 8'h00);
    // R3: enable interrupt with byte pending, then drain
    step(0, 0, 0, 0, 8'h00, 2'd2, 0, 1, 8'h01);
    idle();
    cpu_read(2'd0);
    idle();
    // R2: same-cycle host write and CPU drain keep flag set
    step(1, 0, 0, 1, 8'h11, 2'd3, 0, 0, 8'h00);
    step(1, 0, 0, 1, 8'h22, 2'd0, 1, 0, 8'h00);
    chk("R2 ibf kept", {7'b0, m_ibf}, 8'h01);
    cpu_read(2'd1);
    cpu_read(2'd0);
    // R1: same-cycle CPU write and host data read keep flag set
    step(1, 0, 1, 0, 8'h00, 2'd0, 0, 1, 8'h77);
    step(1, 1, 1, 0, 8'h00, 2'd3, 0, 0, 8'h00);
    step(1, 0, 1, 0, 8'h00, 2'd3, 0, 0, 8'h00);
    // R6: CPU status write touches only bits 2 and 7:4
    step(1, 1, 0, 1, 8'h01, 2'd1, 0, 1, 8'hff);
    step(0, 0, 0, 0, 8'h00, 2'd1, 0, 1, 8'h00);
    step(0, 0, 0, 0, 8'h00, 2'd1, 0, 1, 8'h0b);
    cpu_read(2'd1);
    step(0, 0, 0, 0, 8'h00, 2'd1, 0, 1, 8'hf4);
    // R5: chip select low blocks the host
    step(0, 1, 1, 1, 8'h99, 2'd3, 0, 0, 8'h00);
    cpu_read(2'd1);
    cpu_read(2'd3);
    // R8: a pulse one cycle short changes nothing
    pulse_rst(MINR - 1);
    cpu_read(2'd1);
    cpu_read(2'd2);
    chk("R8 short pulse kept status", {m_ud, 4'h0}, 8'hf0);
    // R8/R7: exact minimum length clears
    pulse_rst(MINR);
    cpu_read(2'd1);
    cpu_read(2'd2);
    chk("R8 min pulse cleared", m_stat(), 8'h00);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int hop, cop;
      hop = $urandom % 4;
      cop = $urandom % 5;
      step(($urandom % 8) != 0, $urandom % 2, hop == 2, hop == 1,
           8'($urandom), 2'($urandom % 4), cop == 2, cop == 1, 8'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule